// File: doc/BRIEF.md
# Chip-RAM Bus Slot Arbiter

The block decides, one bus cycle at a time, who owns a shared memory bus: fixed display DMA, the blitter, or a processor that is waiting for a memory access. Display DMA always owns the cycles it marks as busy. The blitter takes the remaining cycles while a blit is running. A processor request only gets a cycle once the bus is not otherwise claimed, or once a starvation guard decides the processor has waited long enough.

The starvation guard counts the cycles in which the processor asked for the bus and lost it to DMA or to the blitter. When the blitter-priority input is low and the count has reached its limit, the next free cycle goes to the processor even if the blitter also wants it. When the blitter-priority input is high, the blitter keeps every free cycle and the processor waits until the blit is over. Grants are registered, so they appear one cycle after the inputs that caused them.

Top module: `bus_slot_arbiter`

## Requirements
- R1: While reset is asserted all three grants are low, and after reset the denial count starts at zero.
- R2: A cycle with `dmaBusy` high gives `grantDma` in the following cycle, and no other grant.
- R3: With `blitActive` and `blitReq` high, `dmaBusy` low and no starvation takeover, the blitter is granted in the following cycle.
- R4: Each cycle in which `cpuReq` is high and the bus goes to DMA or to the blitter raises the denial count by one. The count saturates at `DENY_LIMIT` (default 3).
- R5: With `blitPrio` low, the count at `DENY_LIMIT`, `dmaBusy` low and `cpuReq` high, the processor gets the cycle instead of the blitter. A processor grant clears the count to zero.
- R6: With `blitPrio` high, the blitter wins every cycle that is not DMA-busy while it requests, whatever the count.
- R7: With `blitActive` low, `blitReq` is ignored and a requesting processor gets the first cycle that is not DMA-busy.
- R8: In cycles where `cpuReq` is low, the count holds its value.
- R9: At most one grant is high in any cycle, and every grant is registered one cycle after its request inputs.
- R10: A cycle with no DMA, no effective blitter request and no processor request gives no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dmaBusy | input | 1 | This cycle belongs to fixed display DMA |
| blitActive | input | 1 | A blit is in progress |
| blitReq | input | 1 | The blitter wants this cycle |
| cpuReq | input | 1 | The processor is waiting for a bus cycle |
| blitPrio | input | 1 | Blitter priority: when high, the processor is given no guaranteed slot |
| grantDma | output | 1 | Previous cycle granted to DMA |
| grantBlit | output | 1 | Previous cycle granted to the blitter |
| grantCpu | output | 1 | Previous cycle granted to the processor |

## Verification
The bench goes after the exact cycle of the starvation takeover. An off-by-one count would hand over the processor slot one cycle early or late, and a count that fails to saturate would wrap and starve the processor for a further four cycles. It checks that DMA-busy cycles also count as denials, that the count holds while the processor is idle, and that a priority-high blit never yields. A design that wrongly let `blitReq` through while no blit is running would take cycles that belong to the processor. Long pseudo-random runs with the priority flag held low, held high, and toggling compare every grant against an arithmetic model of the count.

// File: rtl/bus_slot_arbiter_pkg.sv
package bus_slot_arbiter_pkg;

  // Strobes from the decision logic to the registered datapath
  typedef struct packed {
    logic takeDma;
    logic takeBlit;
    logic takeCpu;
    logic denyInc;
    logic denyClr;
  } slotCtrl_t;

endpackage

// File: rtl/bus_slot_ctrl.sv
module bus_slot_ctrl
  import bus_slot_arbiter_pkg::*;
#(
  parameter int DENY_LIMIT = 3,
  localparam int CNT_W = $clog2(DENY_LIMIT + 1)
) (
  input  logic             dmaBusy,
  input  logic             blitActive,
  input  logic             blitReq,
  input  logic             cpuReq,
  input  logic             blitPrio,
  input  logic [CNT_W-1:0] denyCnt,
  output slotCtrl_t        ctrl
);

  logic blitWants;
  logic cpuStarved;

  always_comb begin
    blitWants  = blitReq && blitActive;
    cpuStarved = cpuReq && !blitPrio && (denyCnt == CNT_W'(DENY_LIMIT));
    ctrl       = '0;
    if (dmaBusy) begin
      ctrl.takeDma = 1'b1;
      ctrl.denyInc = cpuReq;
    end else if (blitWants && !cpuStarved) begin
      ctrl.takeBlit = 1'b1;
      ctrl.denyInc  = cpuReq;
    end else if (cpuReq) begin
      ctrl.takeCpu = 1'b1;
      ctrl.denyClr = 1'b1;
    end
  end

endmodule

// File: rtl/bus_slot_datapath.sv
module bus_slot_datapath
  import bus_slot_arbiter_pkg::*;
#(
  parameter int DENY_LIMIT = 3,
  localparam int CNT_W = $clog2(DENY_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  slotCtrl_t        ctrl,
  output logic [CNT_W-1:0] denyCnt,
  output logic             grantDma,
  output logic             grantBlit,
  output logic             grantCpu
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      denyCnt <= '0;
    end else if (ctrl.denyClr) begin
      denyCnt <= '0;
    end else if (ctrl.denyInc && (denyCnt != CNT_W'(DENY_LIMIT))) begin
      denyCnt <= denyCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantDma  <= 1'b0;
      grantBlit <= 1'b0;
      grantCpu  <= 1'b0;
    end else begin
      grantDma  <= ctrl.takeDma;
      grantBlit <= ctrl.takeBlit;
      grantCpu  <= ctrl.takeCpu;
    end
  end

endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter
  import bus_slot_arbiter_pkg::*;
#(
  parameter int DENY_LIMIT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic dmaBusy,
  input  logic blitActive,
  input  logic blitReq,
  input  logic cpuReq,
  input  logic blitPrio,
  output logic grantDma,
  output logic grantBlit,
  output logic grantCpu
);

  localparam int CNT_W = $clog2(DENY_LIMIT + 1);

  slotCtrl_t        ctrl;
  logic [CNT_W-1:0] denyCnt;

  bus_slot_ctrl #(.DENY_LIMIT(DENY_LIMIT)) u_ctrl (
    .dmaBusy    (dmaBusy),
    .blitActive (blitActive),
    .blitReq    (blitReq),
    .cpuReq     (cpuReq),
    .blitPrio   (blitPrio),
    .denyCnt    (denyCnt),
    .ctrl       (ctrl)
  );

  bus_slot_datapath #(.DENY_LIMIT(DENY_LIMIT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .denyCnt   (denyCnt),
    .grantDma  (grantDma),
    .grantBlit (grantBlit),
    .grantCpu  (grantCpu)
  );

endmodule

// File: rtl/bus_slot_arbiter_chk.sv
module bus_slot_arbiter_chk (
  input logic clk,
  input logic rstN,
  input logic dmaBusy,
  input logic blitActive,
  input logic blitReq,
  input logic cpuReq,
  input logic blitPrio,
  input logic grantDma,
  input logic grantBlit,
  input logic grantCpu
);

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({grantDma, grantBlit, grantCpu}));

  // R2
  dma_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaBusy |=> grantDma);

  // R6
  prio_blit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blitPrio && blitActive && blitReq && !dmaBusy) |=> grantBlit);

  // R7
  idle_blit_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!blitActive && cpuReq && !dmaBusy) |=> grantCpu);

  // R10
  no_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaBusy && !cpuReq && !(blitActive && blitReq)) |=>
      !(grantDma || grantBlit || grantCpu));

endmodule

bind bus_slot_arbiter bus_slot_arbiter_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dmaBusy    (dmaBusy),
  .blitActive (blitActive),
  .blitReq    (blitReq),
  .cpuReq     (cpuReq),
  .blitPrio   (blitPrio),
  .grantDma   (grantDma),
  .grantBlit  (grantBlit),
  .grantCpu   (grantCpu)
);

// File: tb/bus_slot_arbiter_bench.sv
`timescale 1ns/1ps
module bus_slot_arbiter_bench;

  localparam int LIMIT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaBusy = 1'b0, blitActive = 1'b0, blitReq = 1'b0, cpuReq = 1'b0, blitPrio = 1'b0;
  logic grantDma, grantBlit, grantCpu;

  int checks = 0;
  int errors = 0;
  int modelCnt = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  bus_slot_arbiter #(.DENY_LIMIT(LIMIT)) u_bus_slot_arbiter (
    .clk(clk), .rstN(rstN), .dmaBusy(dmaBusy), .blitActive(blitActive),
    .blitReq(blitReq), .cpuReq(cpuReq), .blitPrio(blitPrio),
    .grantDma(grantDma), .grantBlit(grantBlit), .grantCpu(grantCpu)
  );

  task automatic check3(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: grants {dma,blit,cpu} actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, predict, and check at the next falling edge
  task automatic step(input logic d, input logic a, input logic b, input logic c,
                      input logic p, input string tag);
    logic [2:0] exp;
    dmaBusy = d; blitActive = a; blitReq = b; cpuReq = c; blitPrio = p;
    if (d) begin
      exp = 3'b100;
      if (c && modelCnt < LIMIT) modelCnt++;
    end else if (a && b && !(c && !p && modelCnt == LIMIT)) begin
      exp = 3'b010;
      if (c && modelCnt < LIMIT) modelCnt++;
    end else if (c) begin
      exp = 3'b001;
      modelCnt = 0;
    end else begin
      exp = 3'b000;
    end
    @(posedge clk);
    @(negedge clk);
    check3({grantDma, grantBlit, grantCpu}, exp, tag);
  endtask

  task automatic nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cpuReq = 1'b1; blitActive = 1'b1; blitReq = 1'b1; dmaBusy = 1'b1;
    repeat (3) @(negedge clk);
    // R1: grants stay low while in reset
    check3({grantDma, grantBlit, grantCpu}, 3'b000, "R1 reset");
    rstN = 1'b1;
    modelCnt = 0;

    // R1/R5: count starts at zero: three blit wins, then the processor
    step(0,1,1,1,0, "R1 blit after reset");
    step(0,1,1,1,0, "R3 blit second");
    step(0,1,1,1,0, "R4 blit third");
    step(0,1,1,1,0, "R5 cpu takeover");
    step(0,1,1,1,0, "R5 count cleared");
    // R4: DMA denials count too, and saturate
    step(0,1,1,0,0, "R3 blit alone");
    for (int i = 0; i < 6; i++) step(1,1,1,1,0, "R4 dma denial saturates");
    step(0,1,1,1,0, "R5 cpu after dma denials");
    // R8: count holds while processor idle
    step(1,1,1,1,0, "R4 one denial");
    step(1,1,1,1,0, "R4 two denials");
    for (int i = 0; i < 5; i++) step(0,1,1,0,0, "R8 hold while idle");
    step(0,1,1,1,0, "R8 third denial");
    step(0,1,1,1,0, "R8 takeover after hold");
    // R6: priority blit never yields
    for (int i = 0; i < 10; i++) step(0,1,1,1,1, "R6 prio blit");
    step(0,0,0,1,1, "R7 blit ended cpu served");
    // R7: blitReq ignored without active blit
    step(0,0,1,1,0, "R7 cpu first free");
    step(0,0,1,0,0, "R7 stray blitReq no grant");
    step(1,0,0,1,0, "R2 dma first");
    step(0,0,0,1,0, "R7 cpu after dma");
    // R10: idle
    step(0,0,0,0,0, "R10 idle");
    step(0,1,0,0,1, "R10 active but no req");

    // R9: pseudo-random sweep with priority low, high, toggling
    for (int phase = 0; phase < 3; phase++) begin
      for (int i = 0; i < 4000; i++) begin
        logic p;
        nextRand();
        p = (phase == 0) ? 1'b0 : (phase == 1) ? 1'b1 : lfsr[9];
        step(lfsr[0] & lfsr[1], lfsr[2] | lfsr[7], lfsr[3] | lfsr[5], lfsr[4] | lfsr[6], p,
             "R9 sweep");
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule